// File: doc/BRIEF.md
# Multi-Toggle Horizontal Blanking Generator

This block produces the horizontal blanking signal for one image line and gates a pair of horizontal shift clocks with it. A pixel counter restarts at every line-start strobe. Six programmable level-flip positions are compared against that counter. When an enabled position is reached, the blanking level inverts. Two positions give an ordinary start/stop blanking window. Further positions cut extra pulse groups into the interval. The pattern changes only through the position and enable inputs; no other logic changes.

The two horizontal clock phases run in anti-phase while blanking is inactive. While blanking is active they are frozen, with the first phase high and the second low. The blanking output polarity is selectable. Choosing among several stored blanking sequences is done by a neighbouring block, which drives the position and enable inputs of this one.

Top module: `hblk_multi_toggle`

## Requirements
- R1: After reset, before any toggle, blanking is inactive: `hblk` equals `~blank_pol`, `h1` is 0 and `h2` is 1.
- R2: In the clock cycle after a cycle with `line_start` high, the pixel count is 0 and blanking is inactive, whatever the previous level was.
- R3: In every cycle without `line_start`, the pixel count rises by 1 and holds at 8191 (13-bit maximum) without wrapping. Toggle positions are therefore never matched a second time in one line.
- R4: Counting the first cycle after the line-start edge as count 0, an enabled toggle at position p inverts blanking from count p+1 onward.
- R5: A toggle whose enable bit (`tog_en[i]` for slot i) is 0 has no effect on blanking.
- R6: A toggle whose position is not below `line_len` is skipped.
- R7: Several enabled toggles holding the same position invert blanking only once at that count.
- R8: With only slots 0 and 1 enabled at positions a<b, blanking is active exactly for counts a+1 to b.
- R9: With all six slots enabled at ascending positions t0..t5, blanking is active for counts t0+1..t1, t2+1..t3 and t4+1..t5. This gives a main interval plus two more pulse groups.
- R10: `hblk` equals the internal blanking level when `blank_pol` is 1 and its inverse when `blank_pol` is 0.
- R11: While blanking is active, `h1` is 1 and `h2` is 0.
- R12: While blanking is inactive, `h2` is the inverse of `h1`. `h1` is 0 at count 0 and alternates every clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe that restarts the line |
| line_len | input | 13 | Line length; toggles at or above it are skipped |
| tog_pos | input | 6x13 | Toggle positions, slot 0 in the low bits |
| tog_en | input | 6 | Per-slot toggle enable |
| blank_pol | input | 1 | 1: `hblk` high while blanking; 0: low while blanking |
| hblk | output | 1 | Horizontal blanking output |
| h1 | output | 1 | First horizontal clock phase, gated |
| h2 | output | 1 | Second horizontal clock phase, gated |

## Verification
On every cycle the assertions check the per-clock rules. These are the counter step and saturation, the clear at line start, the rule that blanking flips exactly when a hit occurs and holds otherwise, the free-running clock phase, and the frozen clock levels during blanking. The bench alone can show the resulting line-level shapes. It reaches them by driving chosen configurations and comparing every cycle with a model that derives the level from the parity of distinct valid positions below the count. Those shapes are the standard window, the six-toggle multi-pulse pattern, duplicate positions, disabled and out-of-range slots, inverted polarity and saturation over a full-length line.

// File: rtl/hblk_pkg.sv
package hblk_pkg;
  parameter int NUM_TOG = 6;
  parameter int CNT_W   = 13;

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  typedef logic [CNT_W-1:0] cnt_t;

  // A slot fires when enabled, inside the line and equal to the current count.
  function automatic logic slot_fires(logic en, cnt_t pos, cnt_t cnt, cnt_t len);
    return en && (pos < len) && (pos == cnt);
  endfunction

  // Next count: saturating increment, restarted only by the strobe.
  function automatic cnt_t next_count(cnt_t cnt, logic restart);
    if (restart)
      return '0;
    if (cnt == CNT_MAX)
      return cnt;
    return cnt + 1'b1;
  endfunction
endpackage

// File: rtl/hblk_pix_counter.sv
module hblk_pix_counter
  import hblk_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  output cnt_t cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else
      cnt <= next_count(cnt, line_start);
  end

  a_r2_count_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> cnt == '0);
  a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && cnt != CNT_MAX) |=> cnt == $past(cnt) + 1'b1);
  a_r3_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && cnt == CNT_MAX) |=> cnt == CNT_MAX);
endmodule

// File: rtl/hblk_toggle_match.sv
module hblk_toggle_match
  import hblk_pkg::*;
(
  input  cnt_t                         cnt,
  input  cnt_t                         line_len,
  input  logic [NUM_TOG-1:0][CNT_W-1:0] tog_pos,
  input  logic [NUM_TOG-1:0]            tog_en,
  output logic [NUM_TOG-1:0]            slot_hit
);
  for (genvar i = 0; i < NUM_TOG; i++) begin : g_slot
    assign slot_hit[i] = slot_fires(tog_en[i], tog_pos[i], cnt, line_len);
  end
endmodule

// File: rtl/hblk_level.sv
module hblk_level
  import hblk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               line_start,
  input  logic [NUM_TOG-1:0] slot_hit,
  output logic               blank
);
  // Any number of coincident hits is one inversion.
  logic flip_now;
  assign flip_now = |slot_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      blank <= 1'b0;
    else if (line_start)
      blank <= 1'b0;
    else if (flip_now)
      blank <= ~blank;
  end

  a_r2_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !blank);
  a_r7_single_flip: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && (slot_hit != '0)) |=> blank != $past(blank));
  a_r5_hold_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && (slot_hit == '0)) |=> $stable(blank));
endmodule

// File: rtl/hblk_clk_gate.sv
module hblk_clk_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic line_start,
  input  logic blank,
  output logic h1,
  output logic h2
);
  logic phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      phase <= 1'b0;
    else if (line_start)
      phase <= 1'b0;
    else
      phase <= ~phase;
  end

  assign h1 = blank ? 1'b1 : phase;
  assign h2 = blank ? 1'b0 : ~phase;

  a_r12_phase_restart: assert property (@(posedge clk) disable iff (!rst_n)
    line_start |=> !phase);
  a_r12_phase_runs: assert property (@(posedge clk) disable iff (!rst_n)
    !line_start |=> phase != $past(phase));
endmodule

// File: rtl/hblk_multi_toggle.sv
module hblk_multi_toggle
  import hblk_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          line_start,
  input  logic [CNT_W-1:0]              line_len,
  input  logic [NUM_TOG-1:0][CNT_W-1:0] tog_pos,
  input  logic [NUM_TOG-1:0]            tog_en,
  input  logic                          blank_pol,
  output logic                          hblk,
  output logic                          h1,
  output logic                          h2
);
  cnt_t               pix_cnt;
  logic [NUM_TOG-1:0] slot_hit;
  logic               blank;

  hblk_pix_counter u_cnt (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .cnt(pix_cnt)
  );

  hblk_toggle_match u_match (
    .cnt(pix_cnt), .line_len(line_len), .tog_pos(tog_pos),
    .tog_en(tog_en), .slot_hit(slot_hit)
  );

  hblk_level u_level (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .slot_hit(slot_hit), .blank(blank)
  );

  hblk_clk_gate u_gate (
    .clk(clk), .rst_n(rst_n), .line_start(line_start),
    .blank(blank), .h1(h1), .h2(h2)
  );

  assign hblk = blank_pol ? blank : ~blank;

  a_r11_clocks_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    blank |-> (h1 && !h2));
  a_r12_clocks_opposed: assert property (@(posedge clk) disable iff (!rst_n)
    !blank |-> (h1 != h2));
  a_r6_out_of_line: assert property (@(posedge clk) disable iff (!rst_n)
    (!line_start && pix_cnt >= line_len) |=> $stable(blank));
endmodule

// File: tb/tb_hblk_multi_toggle.sv
module tb_hblk_multi_toggle;
  localparam int N  = 6;
  localparam int W  = 13;
  localparam int MX = 8191;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic line_start = 1'b0;
  logic [W-1:0] line_len = '0;
  logic [N-1:0][W-1:0] tog_pos = '0;
  logic [N-1:0] tog_en = '0;
  logic blank_pol = 1'b1;
  logic hblk, h1, h2;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  hblk_multi_toggle dut (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .line_len(line_len),
    .tog_pos(tog_pos), .tog_en(tog_en), .blank_pol(blank_pol),
    .hblk(hblk), .h1(h1), .h2(h2)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference: level is the parity of distinct valid positions below the count.
  function automatic int ref_blank(int c);
    int par = 0;
    for (int i = 0; i < N; i++) begin
      bit dup = 0;
      if (!tog_en[i] || tog_pos[i] >= line_len || int'(tog_pos[i]) >= c) continue;
      for (int j = 0; j < i; j++)
        if (tog_en[j] && tog_pos[j] == tog_pos[i]) dup = 1;
      if (!dup) par ^= 1;
    end
    return par;
  endfunction

  int mcnt = 0;
  int mph = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      mcnt = 0; mph = 0;
    end else if (line_start) begin
      mcnt = 0; mph = 0;
    end else begin
      if (mcnt < MX) mcnt = mcnt + 1;
      mph ^= 1;
    end
  end

  int seen_blk[64];
  int seen_h1[64];
  always @(posedge clk) begin
    #2;
    if (rst_n && !done) begin
      int b, eh, e1, e2;
      b  = ref_blank(mcnt);
      eh = blank_pol ? b : 1 - b;
      e1 = b ? 1 : mph;
      e2 = b ? 0 : 1 - mph;
      chk(hblk == eh, "R8/R10 hblk", hblk, eh);
      chk(h1 == e1, b ? "R11 h1" : "R12 h1", h1, e1);
      chk(h2 == e2, b ? "R11 h2" : "R12 h2", h2, e2);
      if (mcnt < 64) begin
        seen_blk[mcnt] = blank_pol ? int'(hblk) : 1 - int'(hblk);
        seen_h1[mcnt]  = h1;
      end
    end
  end

  task automatic run_line(int len, int p0, int p1, int p2, int p3, int p4, int p5,
                          logic [N-1:0] en, int ncyc);
    @(negedge clk);
    line_len = W'(len);
    tog_pos[0] = W'(p0); tog_pos[1] = W'(p1); tog_pos[2] = W'(p2);
    tog_pos[3] = W'(p3); tog_pos[4] = W'(p4); tog_pos[5] = W'(p5);
    tog_en = en;
    line_start = 1'b1;
    @(negedge clk);
    line_start = 1'b0;
    repeat (ncyc) @(negedge clk);
  endtask

  initial begin
    #1000000;
    chk(0, "watchdog", 0, 1);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(hblk == 1'b0, "R1 hblk", hblk, 0);
    chk(h1 == 1'b0, "R1 h1", h1, 0);
    chk(h2 == 1'b1, "R1 h2", h2, 1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R8 / R4: standard window 10..20
    run_line(100, 10, 20, 0, 0, 0, 0, 6'b000011, 40);
    chk(seen_blk[10] == 0, "R4 before first", seen_blk[10], 0);
    chk(seen_blk[11] == 1, "R4 after first", seen_blk[11], 1);
    chk(seen_blk[20] == 1, "R8 last active", seen_blk[20], 1);
    chk(seen_blk[21] == 0, "R8 end", seen_blk[21], 0);
    chk(seen_h1[15] == 1, "R11 frozen", seen_h1[15], 1);
    chk(seen_h1[0] == 0 && seen_h1[1] == 1, "R12 alternation", seen_h1[1], 1);

    // R2: strobe in the middle of blanking clears the level
    run_line(100, 3, 50, 0, 0, 0, 0, 6'b000011, 10);
    chk(seen_blk[9] == 1, "R2 pre", seen_blk[9], 1);
    run_line(100, 3, 50, 0, 0, 0, 0, 6'b000011, 2);
    chk(seen_blk[0] == 0, "R2 cleared", seen_blk[0], 0);
    repeat (60) @(negedge clk);

    // R5: disabled end toggle
    run_line(100, 10, 20, 0, 0, 0, 0, 6'b000001, 40);
    chk(seen_blk[30] == 1, "R5 disabled slot", seen_blk[30], 1);

    // R6: end toggle beyond line length
    run_line(15, 10, 20, 0, 0, 0, 0, 6'b000011, 40);
    chk(seen_blk[30] == 1, "R6 out of range", seen_blk[30], 1);

    // R7: duplicate positions flip once
    run_line(100, 10, 10, 20, 0, 0, 0, 6'b000111, 40);
    chk(seen_blk[11] == 1, "R7 duplicate", seen_blk[11], 1);
    chk(seen_blk[21] == 0, "R7 end", seen_blk[21], 0);

    // R9: six toggles, three groups
    run_line(100, 10, 15, 20, 25, 30, 40, 6'b111111, 50);
    chk(seen_blk[13] == 1, "R9 group1", seen_blk[13], 1);
    chk(seen_blk[18] == 0, "R9 gap1", seen_blk[18], 0);
    chk(seen_blk[23] == 1, "R9 group2", seen_blk[23], 1);
    chk(seen_blk[28] == 0, "R9 gap2", seen_blk[28], 0);
    chk(seen_blk[35] == 1, "R9 group3", seen_blk[35], 1);
    chk(seen_blk[41] == 0, "R9 end", seen_blk[41], 0);

    // R10: inverted polarity
    @(negedge clk);
    blank_pol = 1'b0;
    run_line(100, 10, 20, 0, 0, 0, 0, 6'b000011, 15);
    chk(hblk == 1'b0, "R10 active low", hblk, 0);
    repeat (20) @(negedge clk);
    chk(hblk == 1'b1, "R10 inactive high", hblk, 1);
    blank_pol = 1'b1;

    // R3: full line, counter saturates without re-hitting early toggles
    run_line(8191, 5, 8190, 0, 0, 0, 0, 6'b000011, 8230);
    chk(hblk == 1'b0, "R3 saturated", hblk, 0);
    chk(h1 != h2, "R3/R12 phase running", h1, 1 - h2);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule